// File: doc/BRIEF.md
# Two-Way Processor Mailbox

This block lets two processors on one clock exchange 32-bit words. Each side owns a small register window reached through a request port. A word that one side writes into its transmit register lands in a first-in first-out queue, and the other side takes it from its receive register. There is one queue for each direction, and each queue holds `DEPTH` words. The two queues are cross-wired: side A's transmit queue is side B's receive queue, and side B's transmit queue is side A's receive queue.

Each side has its own control state. This covers two fill limits, a pending-interrupt register cleared by writing 1s, an interrupt mask, a force register for testing software handlers, a fault register, a status register and a flush control. Each side drives three level interrupt outputs. One signals that its transmit queue is above its limit, one that its receive queue is above its limit, and one that a fault occurred. Faults are misuse of the block: reading an empty queue, writing a full queue, or writing a register that is read-only.

An access is taken in the clock edge where `req` is high. `ack` and `rdata` are valid in the cycle after that edge. `rdata` is 0 for a write.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous reset, every register and limit is 0, both queues are empty, all interrupt outputs and `ack` are low, and a status read returns 0x1.
- R2: Words written to offset 0x0C on one side are read back from offset 0x10 on the other side in the order written. Each queue holds up to `DEPTH` (8) words. Every request is acknowledged in the following cycle. A read of 0x0C returns 0.
- R3: A write to 0x0C while the own transmit queue is full is dropped, sets fault bit 1 and sets pending bit 2. A read of 0x10 while the own receive queue is empty returns 0, sets fault bit 0 and sets pending bit 2.
- R4: A write to 0x10 or to 0x14 changes no queue and no other register, and it sets pending bit 2.
- R5: The register at 0x00 holds the pending bits: bit 0 transmit level, bit 1 receive level, bit 2 fault. Writing 1s clears the named bits. On every clock edge, bit 0 is set if the transmit count is strictly above the limit at 0x1C, and bit 1 is set if the receive count is strictly above the limit at 0x20. Both use the count and limit before that edge. A set condition wins over a clear in the same edge, and a set bit stays set until software clears it.
- R6: A write to 0x08 stores its low 3 bits, which read back from 0x08, and ORs them into the pending bits.
- R7: Each interrupt output equals the matching bit of the mask at 0x04 ANDed with the pending bit. The output is registered and changes in the same edge as those registers.
- R8: A read of 0x14 returns bit 0 = receive queue empty, bit 1 = transmit queue full, bit 2 = transmit count above its limit, bit 3 = receive count above its limit, with the other bits 0.
- R9: The limits at 0x1C and 0x20 keep only their low log2(`DEPTH`) bits. A write to 0x24 with bit 0 set empties the own transmit queue, and with bit 1 set it empties the own receive queue. A flush wins over a push or pop on that queue in the same edge. 0x24 reads as 0.
- R10: The fault register at 0x18 gathers its bits until software clears them by writing 1s to them.
- R11: When one side pushes and the other pops the same queue in one edge, both take effect. A push onto a full queue is still dropped even if the other side pops it in that edge. A pop from an empty queue still returns 0 and faults, while a push in that edge is kept.
- R12: A read of any other offset, or of an address whose two low bits are not 0, returns 0. A write to such an address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Side A access request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | ADDR_W (6) | Side A byte offset |
| a_wdata | input | DATA_W (32) | Side A write data |
| a_ack | output | 1 | Side A access done, one cycle after request |
| a_rdata | output | DATA_W (32) | Side A read data, valid with ack |
| a_irq_tx_lvl | output | 1 | Side A transmit level interrupt |
| a_irq_rx_lvl | output | 1 | Side A receive level interrupt |
| a_irq_fault | output | 1 | Side A fault interrupt |
| b_req | input | 1 | Side B access request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | ADDR_W (6) | Side B byte offset |
| b_wdata | input | DATA_W (32) | Side B write data |
| b_ack | output | 1 | Side B access done, one cycle after request |
| b_rdata | output | DATA_W (32) | Side B read data, valid with ack |
| b_irq_tx_lvl | output | 1 | Side B transmit level interrupt |
| b_irq_rx_lvl | output | 1 | Side B receive level interrupt |
| b_irq_fault | output | 1 | Side B fault interrupt |

## Verification
Some properties are checked on every cycle. These are the queue count bound, the count holding steady on a simultaneous push and pop, the emptying by flush, the stickiness of pending bits, the fault capture on each kind of misuse, and the gating of each interrupt output by its mask. The scenarios cover what needs a history of traffic: word order across the cross-wired queues, the exact data returned, the status bits at each fill level, the cycle in which a level interrupt appears and re-appears after a clear, and the races between pushes, pops and flushes from the two sides. Those are shown by comparing against the reference model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Word offsets within an endpoint window (byte offset = word * 4).
  localparam int OFS_PEND  = 0;
  localparam int OFS_MASK  = 1;
  localparam int OFS_FORCE = 2;
  localparam int OFS_TX    = 3;
  localparam int OFS_RX    = 4;
  localparam int OFS_STAT  = 5;
  localparam int OFS_FAULT = 6;
  localparam int OFS_TXLIM = 7;
  localparam int OFS_RXLIM = 8;
  localparam int OFS_FLUSH = 9;

  // Interrupt bit positions, shared by pending, mask, force and outputs.
  localparam int IRQ_TXLVL = 0;
  localparam int IRQ_RXLVL = 1;
  localparam int IRQ_FAULT = 2;
  localparam int IRQ_N     = 3;

  // Fault register bits.
  localparam int FLT_POP  = 0;
  localparam int FLT_PUSH = 1;
  localparam int FLT_N    = 2;

  // Status bits.
  localparam int ST_RX_EMPTY = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_TX_ABOVE = 2;
  localparam int ST_RX_ABOVE = 3;

  // Flush control bits.
  localparam int FL_TX = 0;
  localparam int FL_RX = 1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] pop_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              push_ok, pop_ok;

  assign push_ok = push && (count != CNT_W'(DEPTH));
  assign pop_ok  = pop && (count != '0);

  // Storage without reset so that a block RAM can be used.
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= push_data;
  end

  // Registered read port; zero when nothing is popped.
  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (pop_ok) pop_data <= mem[rptr];
    else             pop_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)) else $error("queue count above depth");

  assert_both_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count != '0 && count != CNT_W'(DEPTH) && !flush) |=> $stable(count))
    else $error("simultaneous push and pop changed count");

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH) && !pop && !flush) |=> count == CNT_W'(DEPTH))
    else $error("full queue changed without a pop");

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0) else $error("flush left words behind");
endmodule

// File: rtl/mbx_endpoint.sv
module mbx_endpoint
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LIM_W  = $clog2(DEPTH),
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [IRQ_N-1:0]  irq,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [DATA_W-1:0] rx_pop_data,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_pop,
  output logic              flush_tx,
  output logic              flush_rx
);
  logic [IRQ_N-1:0] pend, mask, force_q;
  logic [FLT_N-1:0] fault;
  logic [LIM_W-1:0] tx_lim, rx_lim;
  logic             rsel_q;
  logic [DATA_W-1:0] csr_q;

  logic              wr, rd, aligned;
  logic [WORD_W-1:0] word;
  logic hit_pend, hit_mask, hit_force, hit_tx, hit_rx, hit_stat;
  logic hit_fault, hit_txlim, hit_rxlim, hit_flush;
  logic tx_full, rx_empty, tx_above, rx_above;
  logic push_err, pop_err, ro_err;
  logic [IRQ_N-1:0] pend_clr, pend_set, pend_n, mask_n;
  logic [FLT_N-1:0] fault_n;
  logic [DATA_W-1:0] csr_d;

  assign wr      = req && we;
  assign rd      = req && !we;
  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  assign hit_pend  = aligned && word == WORD_W'(OFS_PEND);
  assign hit_mask  = aligned && word == WORD_W'(OFS_MASK);
  assign hit_force = aligned && word == WORD_W'(OFS_FORCE);
  assign hit_tx    = aligned && word == WORD_W'(OFS_TX);
  assign hit_rx    = aligned && word == WORD_W'(OFS_RX);
  assign hit_stat  = aligned && word == WORD_W'(OFS_STAT);
  assign hit_fault = aligned && word == WORD_W'(OFS_FAULT);
  assign hit_txlim = aligned && word == WORD_W'(OFS_TXLIM);
  assign hit_rxlim = aligned && word == WORD_W'(OFS_RXLIM);
  assign hit_flush = aligned && word == WORD_W'(OFS_FLUSH);

  assign tx_full  = (tx_count == CNT_W'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign tx_above = (tx_count > CNT_W'(tx_lim));
  assign rx_above = (rx_count > CNT_W'(rx_lim));

  // Queue side effects.
  assign tx_push  = wr && hit_tx && !tx_full;
  assign tx_data  = wdata;
  assign rx_pop   = rd && hit_rx && !rx_empty;
  assign push_err = wr && hit_tx && tx_full;
  assign pop_err  = rd && hit_rx && rx_empty;
  assign ro_err   = wr && (hit_rx || hit_stat);
  assign flush_tx = wr && hit_flush && wdata[FL_TX];
  assign flush_rx = wr && hit_flush && wdata[FL_RX];

  // Next-state of the interrupt and fault registers.
  always_comb begin
    pend_clr = (wr && hit_pend) ? wdata[IRQ_N-1:0] : '0;
    pend_set = (wr && hit_force) ? wdata[IRQ_N-1:0] : '0;
    pend_set[IRQ_TXLVL] = pend_set[IRQ_TXLVL] | tx_above;
    pend_set[IRQ_RXLVL] = pend_set[IRQ_RXLVL] | rx_above;
    pend_set[IRQ_FAULT] = pend_set[IRQ_FAULT] | push_err | pop_err | ro_err;
    pend_n   = (pend & ~pend_clr) | pend_set;
    mask_n   = (wr && hit_mask) ? wdata[IRQ_N-1:0] : mask;
    fault_n  = fault & ~((wr && hit_fault) ? wdata[FLT_N-1:0] : '0);
    fault_n[FLT_POP]  = fault_n[FLT_POP] | pop_err;
    fault_n[FLT_PUSH] = fault_n[FLT_PUSH] | push_err;
  end

  // Read mux for everything except the receive queue.
  always_comb begin
    csr_d = '0;
    if (rd) begin
      if (hit_pend)  csr_d[IRQ_N-1:0] = pend;
      if (hit_mask)  csr_d[IRQ_N-1:0] = mask;
      if (hit_force) csr_d[IRQ_N-1:0] = force_q;
      if (hit_fault) csr_d[FLT_N-1:0] = fault;
      if (hit_txlim) csr_d[LIM_W-1:0] = tx_lim;
      if (hit_rxlim) csr_d[LIM_W-1:0] = rx_lim;
      if (hit_stat) begin
        csr_d[ST_RX_EMPTY] = rx_empty;
        csr_d[ST_TX_FULL]  = tx_full;
        csr_d[ST_TX_ABOVE] = tx_above;
        csr_d[ST_RX_ABOVE] = rx_above;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      mask    <= '0;
      force_q <= '0;
      fault   <= '0;
      tx_lim  <= '0;
      rx_lim  <= '0;
      ack     <= 1'b0;
      rsel_q  <= 1'b0;
      csr_q   <= '0;
      irq     <= '0;
    end else begin
      pend   <= pend_n;
      mask   <= mask_n;
      fault  <= fault_n;
      irq    <= mask_n & pend_n;
      ack    <= req;
      rsel_q <= rd && hit_rx;
      csr_q  <= csr_d;
      if (wr && hit_force) force_q <= wdata[IRQ_N-1:0];
      if (wr && hit_txlim) tx_lim  <= wdata[LIM_W-1:0];
      if (wr && hit_rxlim) rx_lim  <= wdata[LIM_W-1:0];
    end
  end

  assign rdata = rsel_q ? rx_pop_data : csr_q;

  for (genvar k = 0; k < IRQ_N; k++) begin : g_sticky
    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (pend[k] && !(wr && hit_pend && wdata[k])) |=> pend[k])
      else $error("pending bit dropped without a clear");
  end

  assert_tx_level_R5: assert property (@(posedge clk) disable iff (rst)
    tx_above |=> pend[IRQ_TXLVL]) else $error("transmit level not flagged");

  assert_rx_level_R5: assert property (@(posedge clk) disable iff (rst)
    rx_above |=> pend[IRQ_RXLVL]) else $error("receive level not flagged");

  assert_pop_fault_R3: assert property (@(posedge clk) disable iff (rst)
    pop_err |=> (pend[IRQ_FAULT] && fault[FLT_POP] && rdata == '0))
    else $error("empty pop not faulted");

  assert_push_fault_R3: assert property (@(posedge clk) disable iff (rst)
    push_err |=> (pend[IRQ_FAULT] && fault[FLT_PUSH]))
    else $error("full push not faulted");

  assert_ro_write_R4: assert property (@(posedge clk) disable iff (rst)
    ro_err |=> pend[IRQ_FAULT]) else $error("read-only write not faulted");

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (mask & pend)) else $error("interrupt output not mask and pending");

  assert_ack_R2: assert property (@(posedge clk) disable iff (rst)
    req |=> ack) else $error("request not acknowledged");

  assert_flush_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_flush) |=> rdata == '0) else $error("flush control read nonzero");
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_ack,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_tx_lvl,
  output logic              a_irq_rx_lvl,
  output logic              a_irq_fault,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_ack,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_tx_lvl,
  output logic              b_irq_rx_lvl,
  output logic              b_irq_fault
);
  localparam int NSIDE = 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              req   [NSIDE];
  logic              we    [NSIDE];
  logic [ADDR_W-1:0] addr  [NSIDE];
  logic [DATA_W-1:0] wdata [NSIDE];
  logic              ack   [NSIDE];
  logic [DATA_W-1:0] rdata [NSIDE];
  logic [IRQ_N-1:0]  irq   [NSIDE];

  // Per queue g: written by side g, read by the other side.
  logic [CNT_W-1:0]  q_count [NSIDE];
  logic [DATA_W-1:0] q_pop_d [NSIDE];
  logic              ep_push [NSIDE];
  logic [DATA_W-1:0] ep_txd  [NSIDE];
  logic              ep_pop  [NSIDE];
  logic              ep_fltx [NSIDE];
  logic              ep_flrx [NSIDE];

  assign req[0] = a_req;  assign we[0] = a_we;  assign addr[0] = a_addr;  assign wdata[0] = a_wdata;
  assign req[1] = b_req;  assign we[1] = b_we;  assign addr[1] = b_addr;  assign wdata[1] = b_wdata;

  assign a_ack = ack[0];
  assign a_rdata = rdata[0];
  assign a_irq_tx_lvl = irq[0][IRQ_TXLVL];
  assign a_irq_rx_lvl = irq[0][IRQ_RXLVL];
  assign a_irq_fault  = irq[0][IRQ_FAULT];
  assign b_ack = ack[1];
  assign b_rdata = rdata[1];
  assign b_irq_tx_lvl = irq[1][IRQ_TXLVL];
  assign b_irq_rx_lvl = irq[1][IRQ_RXLVL];
  assign b_irq_fault  = irq[1][IRQ_FAULT];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int PEER = NSIDE - 1 - g;

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst       (rst),
      .push      (ep_push[g]),
      .push_data (ep_txd[g]),
      .pop       (ep_pop[PEER]),
      .flush     (ep_fltx[g] || ep_flrx[PEER]),
      .count     (q_count[g]),
      .pop_data  (q_pop_d[g])
    );

    mbx_endpoint #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ep (
      .clk         (clk),
      .rst         (rst),
      .req         (req[g]),
      .we          (we[g]),
      .addr        (addr[g]),
      .wdata       (wdata[g]),
      .ack         (ack[g]),
      .rdata       (rdata[g]),
      .irq         (irq[g]),
      .tx_count    (q_count[g]),
      .rx_count    (q_count[PEER]),
      .rx_pop_data (q_pop_d[PEER]),
      .tx_push     (ep_push[g]),
      .tx_data     (ep_txd[g]),
      .rx_pop      (ep_pop[g]),
      .flush_tx    (ep_fltx[g]),
      .flush_rx    (ep_flrx[g])
    );
  end
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb_top;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int DEP = 8;
  localparam logic [5:0] A_PEND = 6'h00, A_MASK = 6'h04, A_FORCE = 6'h08, A_TX = 6'h0C,
                         A_RX = 6'h10, A_STAT = 6'h14, A_FAULT = 6'h18, A_TXLIM = 6'h1C,
                         A_RXLIM = 6'h20, A_FLUSH = 6'h24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          in_req [2];
  logic          in_we  [2];
  logic [AW-1:0] in_addr[2];
  logic [DW-1:0] in_wd  [2];

  logic a_ack, b_ack, a_t, a_r, a_f, b_t, b_r, b_f;
  logic [DW-1:0] a_rdata, b_rdata;

  ipc_mailbox #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .a_req(in_req[0]), .a_we(in_we[0]), .a_addr(in_addr[0]), .a_wdata(in_wd[0]),
    .a_ack(a_ack), .a_rdata(a_rdata), .a_irq_tx_lvl(a_t), .a_irq_rx_lvl(a_r), .a_irq_fault(a_f),
    .b_req(in_req[1]), .b_we(in_we[1]), .b_addr(in_addr[1]), .b_wdata(in_wd[1]),
    .b_ack(b_ack), .b_rdata(b_rdata), .b_irq_tx_lvl(b_t), .b_irq_rx_lvl(b_r), .b_irq_fault(b_f)
  );

  int checks = 0;
  int fails = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference model state.
  logic [DW-1:0] q0[$];  // A to B
  logic [DW-1:0] q1[$];  // B to A
  logic [2:0] m_pend[2], m_mask[2], m_force[2];
  logic [1:0] m_fault[2];
  logic [2:0] m_tlim[2], m_rlim[2];
  logic       e_ack[2];
  logic [2:0] e_irq[2];
  logic [DW-1:0] e_rd[2];

  function automatic int qsize(int f);
    return (f == 0) ? q0.size() : q1.size();
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q0.delete(); q1.delete();
      for (int i = 0; i < 2; i++) begin
        m_pend[i] = 0; m_mask[i] = 0; m_force[i] = 0; m_fault[i] = 0;
        m_tlim[i] = 0; m_rlim[i] = 0; e_ack[i] = 0; e_irq[i] = 0; e_rd[i] = 0;
      end
    end else begin
      bit do_push[2], do_pop[2], fl_tx[2], fl_rx[2];
      for (int i = 0; i < 2; i++) begin
        int cw, cr;
        logic [2:0] clr, set;
        logic [DW-1:0] rv;
        logic wr, rd;
        cw = qsize(i); cr = qsize(1 - i);
        do_push[i] = 0; do_pop[i] = 0; fl_tx[i] = 0; fl_rx[i] = 0;
        clr = 0; rv = 0;
        set = {1'b0, cr > int'(m_rlim[i]), cw > int'(m_tlim[i])};
        wr = in_req[i] && in_we[i];
        rd = in_req[i] && !in_we[i];
        if (wr) begin
          case (in_addr[i])
            A_PEND:  clr = in_wd[i][2:0];
            A_MASK:  m_mask[i] = in_wd[i][2:0];
            A_FORCE: begin m_force[i] = in_wd[i][2:0]; set |= in_wd[i][2:0]; end
            A_TX:    if (cw < DEP) do_push[i] = 1; else begin m_fault[i][1] = 1; set[2] = 1; end
            A_RX, A_STAT: set[2] = 1;
            A_FAULT: m_fault[i] &= ~in_wd[i][1:0];
            A_TXLIM: m_tlim[i] = in_wd[i][2:0];
            A_RXLIM: m_rlim[i] = in_wd[i][2:0];
            A_FLUSH: begin fl_tx[i] = in_wd[i][0]; fl_rx[i] = in_wd[i][1]; end
            default: ;
          endcase
        end else if (rd) begin
          case (in_addr[i])
            A_PEND:  rv = {29'd0, m_pend[i]};
            A_MASK:  rv = {29'd0, m_mask[i]};
            A_FORCE: rv = {29'd0, m_force[i]};
            A_RX: if (cr > 0) begin
                    do_pop[i] = 1;
                    rv = (i == 0) ? q1[0] : q0[0];
                  end else begin m_fault[i][0] = 1; set[2] = 1; end
            A_STAT:  rv = {28'd0, cr > int'(m_rlim[i]), cw > int'(m_tlim[i]), cw == DEP, cr == 0};
            A_FAULT: rv = {30'd0, m_fault[i]};
            A_TXLIM: rv = {29'd0, m_tlim[i]};
            A_RXLIM: rv = {29'd0, m_rlim[i]};
            default: rv = 0;
          endcase
        end
        m_pend[i] = (m_pend[i] & ~clr) | set;
        e_irq[i] = m_mask[i] & m_pend[i];
        e_ack[i] = in_req[i];
        e_rd[i] = rv;
      end
      if (fl_tx[0] || fl_rx[1]) q0.delete();
      else begin
        if (do_pop[1]) void'(q0.pop_front());
        if (do_push[0]) q0.push_back(in_wd[0]);
      end
      if (fl_tx[1] || fl_rx[0]) q1.delete();
      else begin
        if (do_pop[0]) void'(q1.pop_front());
        if (do_push[1]) q1.push_back(in_wd[1]);
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (chk_on && !done) begin
      for (int i = 0; i < 2; i++) begin
        logic g_ack;
        logic [2:0] g_irq;
        logic [DW-1:0] g_rd;
        g_ack = (i == 0) ? a_ack : b_ack;
        g_irq = (i == 0) ? {a_f, a_r, a_t} : {b_f, b_r, b_t};
        g_rd  = (i == 0) ? a_rdata : b_rdata;
        checks++;
        if (g_ack !== e_ack[i] || g_irq !== e_irq[i] || g_rd !== e_rd[i]) begin
          fails++;
          $display("FAIL %s side%0d t=%0t: actual ack=%0b irq=%03b rdata=%08h expected ack=%0b irq=%03b rdata=%08h",
                   cur_tag, i, $time, g_ack, g_irq, g_rd, e_ack[i], e_irq[i], e_rd[i]);
        end
      end
    end
  end

  task automatic cyc(input logic ar, input logic aw, input logic [5:0] aa, input logic [31:0] ad,
                     input logic br, input logic bw, input logic [5:0] ba, input logic [31:0] bd);
    @(posedge clk); #1;
    in_req[0] = ar; in_we[0] = aw; in_addr[0] = aa; in_wd[0] = ad;
    in_req[1] = br; in_we[1] = bw; in_addr[1] = ba; in_wd[1] = bd;
  endtask
  task automatic idle();                               cyc(0,0,0,0, 0,0,0,0); endtask
  task automatic wa(input logic [5:0] a, input logic [31:0] d); cyc(1,1,a,d, 0,0,0,0); endtask
  task automatic ra(input logic [5:0] a);              cyc(1,0,a,0, 0,0,0,0); endtask
  task automatic wb(input logic [5:0] a, input logic [31:0] d); cyc(0,0,0,0, 1,1,a,d); endtask
  task automatic rb(input logic [5:0] a);              cyc(0,0,0,0, 1,0,a,0); endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  logic [5:0] rnd_map[10] = '{A_PEND, A_MASK, A_FORCE, A_TX, A_RX, A_STAT, A_FAULT, A_TXLIM, A_RXLIM, A_FLUSH};

  initial begin
    for (int i = 0; i < 2; i++) begin in_req[i] = 0; in_we[i] = 0; in_addr[i] = 0; in_wd[i] = 0; end
    @(posedge clk); #1; chk_on = 1;
    idle(); idle();
    @(posedge clk); #1; rst = 0;
    // R1: reset values read back on both sides
    cur_tag = "R1";
    foreach (rnd_map[k]) begin ra(rnd_map[k]); rb(rnd_map[k]); end
    // R2: ordered transfer in both directions
    cur_tag = "R2";
    for (int k = 0; k < 5; k++) wa(A_TX, 32'hA000_0000 + k);
    ra(A_TX);
    for (int k = 0; k < 5; k++) rb(A_RX);
    for (int k = 0; k < 3; k++) wb(A_TX, 32'hB000_0010 + k);
    for (int k = 0; k < 3; k++) ra(A_RX);
    // R5 and R7: level interrupts and sticky pending
    cur_tag = "R5";
    wa(A_MASK, 7); wb(A_MASK, 32'hFFFF_FFFF);
    wa(A_TXLIM, 2); wb(A_RXLIM, 1);
    for (int k = 0; k < 4; k++) wa(A_TX, 32'h5500 + k);
    idle(); ra(A_PEND); rb(A_PEND);
    wa(A_PEND, 7); idle(); ra(A_PEND);
    cur_tag = "R7";
    for (int k = 0; k < 4; k++) rb(A_RX);
    wa(A_PEND, 7); wb(A_PEND, 7); idle(); ra(A_PEND); rb(A_PEND);
    wa(A_MASK, 2); wb(A_MASK, 0);
    // R3 and R10: full push and empty pop
    cur_tag = "R3";
    wa(A_TXLIM, 7); wb(A_RXLIM, 7);
    for (int k = 0; k < 9; k++) wa(A_TX, 32'hC0DE_0000 + k);
    ra(A_STAT); rb(A_STAT); ra(A_FAULT);
    for (int k = 0; k < 9; k++) rb(A_RX);
    rb(A_FAULT); rb(A_PEND);
    cur_tag = "R10";
    rb(A_RX); rb(A_FAULT); wb(A_FAULT, 2); rb(A_FAULT); wb(A_FAULT, 1); rb(A_FAULT);
    wa(A_FAULT, 3); ra(A_FAULT);
    // R4: writes to read-only offsets
    cur_tag = "R4";
    wa(A_PEND, 7); wb(A_TX, 32'h1234); wa(A_RX, 32'hFFFF); wa(A_STAT, 32'hFFFF);
    ra(A_PEND); ra(A_STAT); ra(A_TX); ra(A_RX); ra(A_RX);
    // R6: force register
    cur_tag = "R6";
    wa(A_PEND, 7); wa(A_MASK, 7); wa(A_FORCE, 32'hFFFF_FFFD); ra(A_FORCE); ra(A_PEND);
    wa(A_FORCE, 0); wa(A_PEND, 7); ra(A_PEND);
    // R8: status at several fill levels
    cur_tag = "R8";
    wa(A_TXLIM, 3); wb(A_RXLIM, 5);
    for (int k = 0; k < 8; k++) begin wa(A_TX, k); ra(A_STAT); rb(A_STAT); end
    // R9: limits truncate, flush control
    cur_tag = "R9";
    wa(A_TXLIM, 32'hFF); ra(A_TXLIM); wb(A_RXLIM, 32'hFE); rb(A_RXLIM);
    ra(A_FLUSH); wa(A_FLUSH, 1); rb(A_STAT); rb(A_RX);
    for (int k = 0; k < 4; k++) wb(A_TX, 32'hF00 + k);
    wa(A_FLUSH, 2); ra(A_STAT); ra(A_FLUSH);
    wa(A_TX, 1); wa(A_TX, 2);
    cyc(1,1,A_TX,32'h33, 1,1,A_FLUSH,2);   // flush beats push
    rb(A_STAT); rb(A_RX);
    // R11: simultaneous push and pop
    cur_tag = "R11";
    for (int k = 0; k < 3; k++) wa(A_TX, 32'h700 + k);
    cyc(1,1,A_TX,32'h7FF, 1,0,A_RX,0); rb(A_STAT);
    for (int k = 0; k < 5; k++) wa(A_TX, 32'h800 + k);
    cyc(1,1,A_TX,32'h8FF, 1,0,A_RX,0); ra(A_FAULT); rb(A_STAT);
    wb(A_FLUSH, 2);
    cyc(1,1,A_TX,32'h9AB, 1,0,A_RX,0); rb(A_RX); rb(A_RX); rb(A_FAULT);
    // R12: unmapped and misaligned
    cur_tag = "R12";
    wa(6'h28, 32'hFFFF); ra(6'h28); ra(6'h3C); wb(6'h0D, 32'h55); rb(A_STAT); ra(6'h05); rb(6'h11);
    // R2: mixed traffic on both sides
    cur_tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int sa, sb;
      sa = $urandom_range(0, 19); sb = $urandom_range(0, 19);
      cyc($urandom_range(0, 3) != 0, sa < 12, (sa < 8) ? A_TX : (sa < 10 || sa >= 12 && sa < 16) ? A_RX : rnd_map[$urandom_range(0, 9)],
          (rnd_map[$urandom_range(0, 9)] == A_FLUSH && $urandom_range(0, 3) != 0) ? 0 : $urandom,
          $urandom_range(0, 3) != 0, sb < 12, (sb < 8) ? A_TX : (sb < 10 || sb >= 12 && sb < 16) ? A_RX : rnd_map[$urandom_range(0, 9)],
          $urandom);
    end
    idle(); idle(); idle();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule